// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a 34-bit physical address by reading three levels of page table from memory. A request carries the address, a write flag and a user-mode flag. The walker first checks the upper address bits and the segment they select, and no memory is read if they are malformed. Otherwise it reads one 8-byte entry per level. The first table's frame comes from a base-frame input. Each valid entry's frame number locates the next table, and the last entry's frame number joined with the page offset is the result.

Every walk ends with a one-cycle done pulse. The pulse carries a physical address, a fault code and the level at which the walk stopped. The memory port is single-beat, with one outstanding read. A request is accepted only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: The virtual address layout is fixed. Bits [42:33] index the first level, [32:23] the second level and [22:13] the third level. Bits [12:0] are the page offset. Bits [63:43] select the segment and must be well formed:
  - If bit 63 is 0, bits [62:43] must all be 0.
  - If bits 63 and 62 are both 1, bits [61:43] must all be 1.
  - If bit 63 is 1 and bit 62 is 0, bits [61:43] must all be 0.
  A malformed address ends the walk with fault code 1 and level 0, and no memory read is issued.
- R2: The segment with bit 63 set and bit 62 clear is the kernel segment. A user-mode request (`req_user`=1) to it ends with fault code 1 and no memory read. Kernel-mode requests to it are walked normally.
- R3: The table base frame is taken from `ptbr` at acceptance for the first level, and from the previous entry's frame number after that. Each read address is (base frame × 8192) + index × 8.
- R4: A page-table entry has this format:
  - bit 0: valid
  - bit 1: kernel access
  - bit 2: user access
  - bit 3: read enable
  - bit 4: write enable
  - bits [52:32]: frame number
- R5: An entry whose valid bit is 0, at any level, stops the walk with fault code 2 and the failing level (1, 2 or 3). No further read is issued. Only the valid bit of first- and second-level entries is examined.
- R6: The third-level entry is checked for protection. It needs user access for a user-mode request and kernel access otherwise. It also needs write enable for a write and read enable for a read. A failed check ends with fault code 3 and level 3.
- R7: A successful walk ends with fault code 0 and level 0. Its physical address is {third-level frame number, va[12:0]}.
- R8: A read is issued as a one-cycle `mem_rd_valid` pulse, and the walker waits for `mem_rsp_valid` before going on. There is never more than one read outstanding. A successful walk makes exactly three reads.
- R9: `req_ready` is high only while idle. `done` is a one-cycle pulse per accepted request. A request presented while busy is ignored: it starts no reads and produces no completion.
- R10: During and right after reset, `req_ready` is 1, and `done` and `mem_rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| ptbr | input | 21 | First-level table frame number |
| mem_rd_valid | output | 1 | Memory read issued this cycle |
| mem_rd_addr | output | 34 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 64 | Returned page-table entry |
| done | output | 1 | Result valid pulse |
| rsp_pa | output | 34 | Physical address (valid when fault is 0) |
| rsp_fault | output | 2 | 0 none, 1 address form, 2 invalid entry, 3 protection |
| rsp_level | output | 2 | Level that failed on a page or protection fault |

## Verification
The assertions watch, on every cycle, the properties that do not depend on table contents:
- there is never more than one read outstanding;
- a walk makes at most three reads;
- an address-form fault completes with no read;
- a successful walk completes after exactly three reads;
- a page-fault level equals the number of reads made;
- `done` is a single-cycle pulse while the walker is busy.

Only the bench's scenarios can show table-dependent behaviour. That covers the exact entry addresses, the protection decisions for each combination of mode and write flag, and the physical address assembled from the leaf entry. It also covers requests presented while busy being dropped, under varied memory latencies.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 64,
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 13,
  parameter int PFN_W   = 21,
  parameter int PTE_W   = 64,
  parameter int PFN_LSB = 32,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [PFN_W-1:0] ptbr,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_fault,
  output logic [1:0]       rsp_level
);
  localparam int IMPL_W = 3 * IDX_W + OFF_W;
  localparam int HI_W   = VA_W - 1 - IMPL_W;
  localparam int ENT_SH = $clog2(PTE_W / 8);
  localparam logic [1:0] F_NONE = 2'd0, F_ADDR = 2'd1, F_PAGE = 2'd2, F_PROT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_DONE} state_t;

  state_t            st;
  logic [1:0]        lvl;
  logic [IMPL_W-1:0] va_q;
  logic              wr_q, usr_q;
  logic [PFN_W-1:0]  base_q;
  logic [IDX_W-1:0]  cur_idx;

  logic [HI_W-1:0] hi_a;
  logic [HI_W-2:0] hi_b;
  logic            seg_ok;
  assign hi_a   = req_va[VA_W-2:IMPL_W];
  assign hi_b   = req_va[VA_W-3:IMPL_W];
  assign seg_ok = !req_va[VA_W-1] ? ~|hi_a
                : req_va[VA_W-2]  ? &hi_b
                :                   (~|hi_b & ~req_user);

  logic             pte_v, pte_ka, pte_ua, pte_re, pte_we;
  logic [PFN_W-1:0] pte_pfn;
  assign pte_v   = mem_rsp_data[0];
  assign pte_ka  = mem_rsp_data[1];
  assign pte_ua  = mem_rsp_data[2];
  assign pte_re  = mem_rsp_data[3];
  assign pte_we  = mem_rsp_data[4];
  assign pte_pfn = mem_rsp_data[PFN_LSB +: PFN_W];

  wire unused_pte = ^{mem_rsp_data[PTE_W-1:PFN_LSB+PFN_W], mem_rsp_data[PFN_LSB-1:5]};

  logic access_ok;
  assign access_ok = (usr_q ? pte_ua : pte_ka) && (wr_q ? pte_we : pte_re);

  always_comb begin
    case (lvl)
      2'd1:    cur_idx = va_q[OFF_W + 2*IDX_W +: IDX_W];
      2'd2:    cur_idx = va_q[OFF_W + IDX_W +: IDX_W];
      default: cur_idx = va_q[OFF_W +: IDX_W];
    endcase
  end

  assign mem_rd_addr  = {base_q, {OFF_W{1'b0}}} | (PA_W'(cur_idx) << ENT_SH);
  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = (st == S_RD);
  assign done         = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lvl       <= 2'd0;
      va_q      <= '0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      base_q    <= '0;
      rsp_pa    <= '0;
      rsp_fault <= F_NONE;
      rsp_level <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q      <= req_va[IMPL_W-1:0];
          wr_q      <= req_write;
          usr_q     <= req_user;
          base_q    <= ptbr;
          lvl       <= 2'd1;
          rsp_pa    <= '0;
          rsp_level <= 2'd0;
          if (seg_ok) begin
            rsp_fault <= F_NONE;
            st        <= S_RD;
          end else begin
            rsp_fault <= F_ADDR;
            st        <= S_DONE;
          end
        end
        S_RD: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!pte_v) begin
            rsp_fault <= F_PAGE;
            rsp_level <= lvl;
            st        <= S_DONE;
          end else if (lvl == 2'd3) begin
            if (access_ok) begin
              rsp_pa <= {pte_pfn, va_q[OFF_W-1:0]};
            end else begin
              rsp_fault <= F_PROT;
              rsp_level <= 2'd3;
            end
            st <= S_DONE;
          end else begin
            base_q <= pte_pfn;
            lvl    <= lvl + 2'd1;
            st     <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mem_rd_valid,
  input logic       done,
  input logic [1:0] rsp_fault,
  input logic [1:0] rsp_level
);
  logic [2:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      rd_cnt <= 3'd0;
    else if (req_valid && req_ready) rd_cnt <= 3'd0;
    else if (mem_rd_valid)           rd_cnt <= rd_cnt + 3'd1;
  end

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);
  a_r8_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= 3'd3);
  a_r1_no_read_on_addr_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_fault == 2'd1) |-> rd_cnt == 3'd0);
  a_r7_three_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_fault == 2'd0) |-> rd_cnt == 3'd3);
  a_r5_fault_level: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_fault == 2'd2) |-> {1'b0, rsp_level} == rd_cnt);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (done || mem_rd_valid) |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .done(done), .rsp_fault(rsp_fault), .rsp_level(rsp_level)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [20:0] ptbr = '0;
  logic        mem_rd_valid;
  logic [33:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [33:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [1:0]  rsp_level;

  always #4 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_user(req_user), .ptbr(ptbr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_level(rsp_level)
  );

  logic [63:0] mem [logic [33:0]];
  logic [33:0] exp_q [$];
  logic [1:0]  exp_fault, exp_level;
  logic [33:0] exp_pa;
  int checks = 0, fails = 0, cyc = 0;
  bit busy = 0, seen_done = 0;
  int lat = 1, pend = 0;
  logic [63:0] pend_data;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [33:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  // R4: frame in [52:32]; flags {we,re,ua,ka,v} in [4:0]
  function automatic logic [63:0] pte(input logic [20:0] pfn, input logic [4:0] fl);
    return {11'd0, pfn, 27'd0, fl};
  endfunction

  function automatic logic [63:0] mkva(input logic [20:0] top, input logic [9:0] a,
                                       input logic [9:0] b, input logic [9:0] c,
                                       input logic [12:0] off);
    return {top, a, b, c, off};
  endfunction

  task automatic model(input logic [63:0] va, input logic wr, input logic usr,
                       input logic [20:0] base);
    bit ok;
    logic [20:0] b;
    logic [9:0] idx;
    logic [33:0] a;
    logic [63:0] e;
    exp_q.delete();
    exp_fault = 2'd0; exp_level = 2'd0; exp_pa = '0;
    if (va[63] == 1'b0)  ok = (va[62:43] == 20'd0);
    else if (va[62])     ok = (va[61:43] == {19{1'b1}});
    else                 ok = (va[61:43] == 19'd0) && !usr;
    if (!ok) begin
      exp_fault = 2'd1;
      return;
    end
    b = base;
    for (int l = 1; l <= 3; l++) begin
      idx = (l == 1) ? va[42:33] : (l == 2) ? va[32:23] : va[22:13];
      a = {b, 13'd0} + 34'(idx) * 34'd8;
      exp_q.push_back(a);
      e = rd(a);
      if (!e[0]) begin
        exp_fault = 2'd2;
        exp_level = 2'(l);
        return;
      end
      b = e[52:32];
      if (l == 3) begin
        if (!((usr ? e[2] : e[1]) && (wr ? e[4] : e[3]))) begin
          exp_fault = 2'd3;
          exp_level = 2'd3;
        end else begin
          exp_pa = {b, va[12:0]};
        end
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
    mem_rsp_valid = 1'b0;
    chk("R9 req_ready while idle only", req_ready, !busy);
    if (mem_rd_valid) begin
      if (exp_q.size() == 0) chk("R8 unexpected read", 1, 0);
      else                   chk("R3 entry address", mem_rd_addr, exp_q.pop_front());
    end
    if (done) begin
      chk("R9 done only for accepted request", busy, 1);
      chk("R1/R5/R6 fault code", rsp_fault, exp_fault);
      chk("R5 fault level", rsp_level, exp_level);
      if (exp_fault == 2'd0) chk("R7 physical address", rsp_pa, exp_pa);
      chk("R8 read count", exp_q.size(), 0);
      busy = 0;
      seen_done = 1;
    end
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pend_data;
      end
    end
    if (mem_rd_valid) begin
      pend_data = rd(mem_rd_addr);
      pend = lat;
    end
  endtask

  task automatic walk(input logic [63:0] va, input logic wr, input logic usr,
                      input logic [20:0] base, input int l, input int noise);
    model(va, wr, usr, base);
    lat = l;
    req_va = va; req_write = wr; req_user = usr; ptbr = base;
    req_valid = 1'b1; busy = 1; seen_done = 0;
    step();
    if (noise > 0) begin
      req_va = va ^ 64'h0000_0000_0000_2000;
      req_write = !wr;
      for (int n = 0; n < noise; n++) step();
    end
    req_valid = 1'b0;
    for (int i = 0; i < 400 && !seen_done; i++) step();
    if (!seen_done) chk("R9 walk completes", 0, 1);
    step();
  endtask

  localparam logic [20:0] SEG0 = 21'h000000, STK = 21'h1FFFFF, KSEG = 21'h100000;

  initial begin
    mem[{21'h100, 13'd0} + 34'd8]    = pte(21'h200, 5'b00001);
    mem[{21'h100, 13'd0} + 34'd8184] = pte(21'h200, 5'b00001);
    mem[{21'h180, 13'd0} + 34'd8]    = pte(21'h240, 5'b00001);
    mem[{21'h240, 13'd0} + 34'd16]   = pte(21'h300, 5'b00001);
    mem[{21'h200, 13'd0} + 34'd16]   = pte(21'h300, 5'b00001);
    mem[{21'h300, 13'd0} + 34'd24]   = pte(21'h1ABCD, 5'b11111);
    mem[{21'h300, 13'd0} + 34'd32]   = pte(21'h00777, 5'b01011);
    mem[{21'h300, 13'd0} + 34'd64]   = pte(21'h0BEEF, 5'b01101);

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready in reset", req_ready, 1);
    chk("R10 done in reset", done, 0);
    chk("R10 no read in reset", mem_rd_valid, 0);
    rst_n = 1'b1;
    step();
    chk("R10 idle after reset", {req_ready, done, mem_rd_valid}, 3'b100);

    walk(mkva(SEG0, 10'd1, 10'd2, 10'd3, 13'h123), 0, 1, 21'h100, 1, 0); // R7 user read
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd3, 13'h1FFF), 1, 1, 21'h100, 3, 0); // R7 user write
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd4, 13'h004), 0, 1, 21'h100, 2, 0); // R6 no user access
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd4, 13'h004), 0, 0, 21'h100, 1, 0); // R6 kernel read ok
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd4, 13'h004), 1, 0, 21'h100, 1, 0); // R6 no write enable
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd8, 13'h0AA), 1, 1, 21'h100, 1, 0); // R6 user write read-only
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd8, 13'h0AA), 0, 1, 21'h100, 1, 0); // R6 user read ok
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd5, 13'h000), 0, 0, 21'h100, 1, 0); // R5 level 3
    walk(mkva(SEG0, 10'd1, 10'd6, 10'd3, 13'h000), 0, 0, 21'h100, 2, 0); // R5 level 2
    walk(mkva(SEG0, 10'd7, 10'd2, 10'd3, 13'h000), 0, 0, 21'h100, 1, 0); // R5 level 1
    walk(mkva(21'h000001, 10'd1, 10'd2, 10'd3, 13'h0), 0, 0, 21'h100, 1, 0); // R1 bad seg0
    walk(mkva(21'h080000, 10'd1, 10'd2, 10'd3, 13'h0), 0, 0, 21'h100, 1, 0); // R1 bit62 in seg0
    walk(mkva(STK, 10'd1023, 10'd2, 10'd3, 13'h055), 0, 1, 21'h100, 2, 0);  // R1 stack ok
    walk(mkva(21'h1FFFFE, 10'd1023, 10'd2, 10'd3, 13'h0), 0, 1, 21'h100, 1, 0); // R1 bad stack
    walk(mkva(KSEG, 10'd1, 10'd2, 10'd3, 13'h0777), 1, 0, 21'h100, 1, 0); // R2 kernel ok
    walk(mkva(KSEG, 10'd1, 10'd2, 10'd3, 13'h0777), 0, 1, 21'h100, 1, 0); // R2 user faults
    walk(mkva(21'h100001, 10'd1, 10'd2, 10'd3, 13'h0), 0, 0, 21'h100, 1, 0); // R1 bad kseg
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd3, 13'h010), 0, 0, 21'h180, 2, 0); // R3 other base
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd3, 13'h321), 0, 1, 21'h100, 5, 4); // R9 busy ignored
    walk(mkva(SEG0, 10'd1, 10'd2, 10'd3, 13'h321), 0, 1, 21'h100, 7, 0); // R8 long latency

    for (int i = 0; i < 4; i++) step(); // R9 no stray activity when idle
    summary();
  end
endmodule